// File: doc/BRIEF.md
# Lane Test Pattern Generator

This block sits between the per-lane 8B/10B encoders and the serializers of a four-lane link. Each clock it presents one 10-bit code group per lane. In normal operation it forwards the encoded groups unchanged. When the management side sets a test enable and picks a pattern with a 2-bit select, it replaces every lane's group with a fixed compliance pattern.

Three patterns exist. The first is a fast toggle. The second is a slow square wave of five ones and five zeros. The third is a 20-bit mixed pattern made of two alternating 10-bit halves. Bits leave each group most significant bit first, so bit 9 of a group is the first bit on the wire. The select value 11 is reserved and behaves like the disabled state. The output is registered, so a change of enable or select affects only whole groups.

Top module: `lane_test_pattern`

## Requirements
- R1: While `rst_n` is low, `lane_dout` is all zeros.
- R2: With `test_en` low, each clock `lane_dout` equals the `lane_din` sampled at the previous rising edge.
- R3: With `test_en` high and `test_sel` = 00, every lane group on the next cycle is 10'b1010101010 (0x2AA), with bit 9 first on the wire.
- R4: With `test_en` high and `test_sel` = 01, every lane group on the next cycle is 10'b1111100000 (0x3E0).
- R5: With `test_en` high and `test_sel` = 10 held, the lane groups alternate between 10'b1111101011 (0x3EB) and 10'b0000010100 (0x014) on consecutive cycles.
- R6: With `test_en` high and `test_sel` = 11, the block forwards data exactly as in R2.
- R7: The first mixed group after the mixed selection begins is 0x3EB. This holds after reset, after `test_en` rises, and after `test_sel` changes to 10 from any other value.
- R8: Whenever a pattern is active, all lanes carry the same group in the same cycle.
- R9: Enable, select and data are sampled only at the rising clock edge. Between edges the output holds its current group, so no group is ever truncated.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Group clock; one code group per lane per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| test_en | input | 1 | Enables substitution of the test pattern |
| test_sel | input | 2 | Pattern choice: 00 fast toggle, 01 slow square, 10 mixed, 11 reserved |
| lane_din | input | NUM_LANES*10 | Encoded groups; lane k in bits [10k+9:10k] |
| lane_dout | output | NUM_LANES*10 | Groups to the serializers, same lane layout |

## Verification
The bench builds the block with the default of four lanes. This keeps the lane-equality rule meaningful and lets a lane-placement slip in the passthrough show up on random data. Directed runs enter and leave the mixed pattern by every route: reset release, enable rising, and select changes from each other code, including the reserved one. These routes exercise the phase restart. A long random stretch then changes enable and select every few cycles, so the 20-bit pattern is also entered from odd and even phases.

// File: rtl/ltpg_pkg.sv
package ltpg_pkg;

    localparam int GW = 10;

    typedef logic [GW-1:0] grp_t;

    typedef enum logic [1:0] {
        M_PASS = 2'd0,
        M_HIGH = 2'd1,
        M_LOW  = 2'd2,
        M_MIX  = 2'd3
    } mode_t;

    // Bit 9 leaves the serializer first.
    localparam grp_t W_HIGH  = 10'b1010101010;
    localparam grp_t W_LOW   = 10'b1111100000;
    localparam grp_t W_MIX_A = 10'b1111101011;
    localparam grp_t W_MIX_B = 10'b0000010100;

endpackage

// File: rtl/ltpg_mode_dec.sv
module ltpg_mode_dec
    import ltpg_pkg::*;
(
    input  logic       en,
    input  logic [1:0] sel,
    output mode_t      mode
);
    always_comb begin
        mode = M_PASS;
        if (en) begin
            unique case (sel)
                2'b00:   mode = M_HIGH;
                2'b01:   mode = M_LOW;
                2'b10:   mode = M_MIX;
                default: mode = M_PASS; // reserved code forwards data
            endcase
        end
    end
endmodule

// File: rtl/ltpg_phase.sv
module ltpg_phase
    import ltpg_pkg::*;
(
    input  mode_t cur_mode,
    input  mode_t last_mode,
    input  logic  half_q,
    output logic  use_b,
    output logic  half_d
);
    logic continuing;

    always_comb begin
        continuing = (cur_mode == M_MIX) && (last_mode == M_MIX);
        use_b      = continuing ? half_q : 1'b0;
        half_d     = (cur_mode == M_MIX) ? ~use_b : 1'b0;
    end
endmodule

// File: rtl/ltpg_lane_mux.sv
module ltpg_lane_mux
    import ltpg_pkg::*;
(
    input  mode_t mode,
    input  logic  use_b,
    input  grp_t  din,
    output grp_t  dout
);
    always_comb begin
        unique case (mode)
            M_HIGH:  dout = W_HIGH;
            M_LOW:   dout = W_LOW;
            M_MIX:   dout = use_b ? W_MIX_B : W_MIX_A;
            default: dout = din;
        endcase
    end
endmodule

// File: rtl/lane_test_pattern.sv
module lane_test_pattern
    import ltpg_pkg::*;
#(
    parameter int NUM_LANES = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    test_en,
    input  logic [1:0]              test_sel,
    input  logic [NUM_LANES*GW-1:0] lane_din,
    output logic [NUM_LANES*GW-1:0] lane_dout
);
    localparam int BUS_W = NUM_LANES * GW;

    typedef struct packed {
        mode_t            last_mode;
        logic             half;
        logic [BUS_W-1:0] dout;
    } state_t;

    state_t state_d, state_q;

    mode_t            cur_mode;
    logic             use_b;
    logic             half_nx;
    logic [BUS_W-1:0] mux_out;

    ltpg_mode_dec u_dec (
        .en   (test_en),
        .sel  (test_sel),
        .mode (cur_mode)
    );

    ltpg_phase u_phase (
        .cur_mode  (cur_mode),
        .last_mode (state_q.last_mode),
        .half_q    (state_q.half),
        .use_b     (use_b),
        .half_d    (half_nx)
    );

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        ltpg_lane_mux u_mux (
            .mode  (cur_mode),
            .use_b (use_b),
            .din   (lane_din[g*GW +: GW]),
            .dout  (mux_out[g*GW +: GW])
        );
    end

    always_comb begin
        state_d           = state_q;
        state_d.last_mode = cur_mode;
        state_d.half      = half_nx;
        state_d.dout      = mux_out;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '{last_mode: M_PASS, half: 1'b0, dout: '0};
        end else begin
            state_q <= state_d;
        end
    end

    assign lane_dout = state_q.dout;

endmodule

// File: rtl/ltpg_checker.sv
module ltpg_checker
    import ltpg_pkg::*;
#(
    parameter int NUM_LANES = 4
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    test_en,
    input logic [1:0]              test_sel,
    input logic [NUM_LANES*GW-1:0] lane_din,
    input logic [NUM_LANES*GW-1:0] lane_dout
);
    logic all_high, all_low, lanes_same, mix_in, pat_in;
    grp_t lane0;

    always_comb begin
        lane0      = lane_dout[GW-1:0];
        all_high   = 1'b1;
        all_low    = 1'b1;
        lanes_same = 1'b1;
        for (int k = 0; k < NUM_LANES; k++) begin
            if (lane_dout[k*GW +: GW] != W_HIGH) all_high = 1'b0;
            if (lane_dout[k*GW +: GW] != W_LOW)  all_low  = 1'b0;
            if (lane_dout[k*GW +: GW] != lane0)  lanes_same = 1'b0;
        end
        mix_in = test_en && (test_sel == 2'b10);
        pat_in = test_en && (test_sel != 2'b11);
    end

    a_r1_reset_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (lane_dout == '0));

    a_r2_pass: assert property (@(posedge clk) disable iff (!rst_n)
        !test_en |=> (lane_dout == $past(lane_din)));

    a_r3_high: assert property (@(posedge clk) disable iff (!rst_n)
        (test_en && test_sel == 2'b00) |=> all_high);

    a_r4_low: assert property (@(posedge clk) disable iff (!rst_n)
        (test_en && test_sel == 2'b01) |=> all_low);

    a_r5_mix_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        (mix_in && $past(mix_in)) |=>
            ((lane0 != $past(lane0)) && (lane0 == W_MIX_A || lane0 == W_MIX_B)));

    a_r6_reserved: assert property (@(posedge clk) disable iff (!rst_n)
        (test_en && test_sel == 2'b11) |=> (lane_dout == $past(lane_din)));

    a_r7_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (mix_in && !$past(mix_in)) |=> (lane0 == W_MIX_A));

    a_r8_lanes_same: assert property (@(posedge clk) disable iff (!rst_n)
        pat_in |=> lanes_same);

endmodule

bind lane_test_pattern ltpg_checker #(.NUM_LANES(NUM_LANES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .test_en   (test_en),
    .test_sel  (test_sel),
    .lane_din  (lane_din),
    .lane_dout (lane_dout)
);

// File: tb/lane_test_pattern_test.sv
module lane_test_pattern_test;
    localparam int NL = 4;
    localparam int BW = NL * 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          test_en = 1'b0;
    logic [1:0]    test_sel = 2'b00;
    logic [BW-1:0] lane_din = '0;
    logic [BW-1:0] lane_dout;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // behavioural model state
    int            m_last = 0;  // 0 pass, 1 high, 2 low, 3 mixed
    bit            m_half = 0;
    logic [BW-1:0] m_exp  = '0;

    always #10 clk = ~clk;

    lane_test_pattern #(.NUM_LANES(NL)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .test_en   (test_en),
        .test_sel  (test_sel),
        .lane_din  (lane_din),
        .lane_dout (lane_dout)
    );

    task automatic check(string req, logic [BW-1:0] act, logic [BW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [BW-1:0] rep(logic [9:0] w);
        logic [BW-1:0] r;
        for (int k = 0; k < NL; k++) r[k*10 +: 10] = w;
        return r;
    endfunction

    // called at a falling edge; drives inputs, checks after the next rising edge
    task automatic cyc(bit en, logic [1:0] sel);
        int mode;
        string tag;
        logic [BW-1:0] d;
        d = {$urandom, $urandom};
        test_en  = en;
        test_sel = sel;
        lane_din = d;
        #1;
        check("R9 output held between edges", lane_dout, m_exp);
        mode = (!en || sel == 2'b11) ? 0 : int'(sel) + 1;
        case (mode)
            0: begin m_exp = d; tag = en ? "R6 reserved passthrough" : "R2 passthrough"; end
            1: begin m_exp = rep(10'h2AA); tag = "R3 high pattern"; end
            2: begin m_exp = rep(10'h3E0); tag = "R4 low pattern"; end
            default: begin
                bit h;
                h = (m_last == 3) ? m_half : 1'b0;
                m_exp  = h ? rep(10'h014) : rep(10'h3EB);
                m_half = !h;
                tag = (m_last == 3) ? "R5 mixed alternation" : "R7 mixed restart";
            end
        endcase
        if (mode != 3) m_half = 0;
        m_last = mode;
        @(posedge clk);
        @(negedge clk);
        check(tag, lane_dout, m_exp);
        if (mode != 0) begin
            for (int k = 1; k < NL; k++)
                check("R8 lanes equal", {{(BW-10){1'b0}}, lane_dout[k*10 +: 10]},
                      {{(BW-10){1'b0}}, lane_dout[9:0]});
        end
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        lane_din = {$urandom, $urandom};
        test_en  = 1'b1;
        repeat (3) begin
            @(negedge clk);
            check("R1 reset output", lane_dout, '0);
        end
        rst_n = 1'b1;
        m_last = 0; m_half = 0; m_exp = '0;
        // mixed directly after reset
        repeat (3) cyc(1, 2'b10);
        repeat (4) cyc(0, 2'b10);
        repeat (3) cyc(1, 2'b00);
        repeat (3) cyc(1, 2'b01);
        repeat (5) cyc(1, 2'b10);
        repeat (3) cyc(1, 2'b11);
        repeat (4) cyc(1, 2'b10);
        cyc(1, 2'b00);
        repeat (3) cyc(1, 2'b10);
        cyc(1, 2'b01);
        repeat (2) cyc(1, 2'b10);
        cyc(0, 2'b10);
        repeat (3) cyc(1, 2'b10);
        repeat (2) cyc(0, 2'b01);
        // random stretch
        for (int i = 0; i < 60; i++) begin
            bit en;
            logic [1:0] sel;
            en  = ($urandom % 4) != 0;
            sel = 2'($urandom);
            repeat (1 + ($urandom % 4)) cyc(en, sel);
        end
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule